// File: doc/BRIEF.md
# I2C Controller Interrupt Vector and Status Unit

This unit sits beside an I2C bus engine and turns the engine's one-cycle event pulses into sticky status flags. A mask register selects which flags may raise the interrupt line. A vector register reports the most urgent pending, enabled event as a 3-bit code. Reading the vector also acknowledges the event it reports, so an interrupt handler can drain all work by reading the vector in a loop until it returns zero.

The register port is plain and has no back-pressure. A read strobe always completes: its data appears on the read bus one clock later and stays there until the next read. Writes take effect on the clock edge that samples them. Bus-busy and receive-shift-full are level inputs that are only reflected in the status word.

Top module: `i2c_irq_vector_unit`

## Requirements
- R1: After reset, all event flags and the mask are zero, the read bus is zero and the interrupt output is low.
- R2: A pulse on event input k sets status bit k on the next clock edge, whether or not the event is enabled. Status bit positions are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. The flag then stays set until it is cleared.
- R3: The vector codes are 1 arbitration lost, 2 NACK, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected and 7 addressed as slave, so flag bit k reports code k+1.
- R4: When several enabled flags are pending, the vector reports the lowest code.
- R5: The vector reads 0 when no enabled flag is pending. A flag whose mask bit is 0 never appears in the vector and stays set.
- R6: A read of the vector clears the flag of the code it returns. If an event pulse for that same flag arrives in the same cycle, the flag stays set.
- R7: Writing 1 to status bit 2 (access ready) or bit 5 (stop detected) clears that flag. Writing to any other status bit has no effect.
- R8: Mask bit k enables event k, using the same bit order as the status flags. The mask reads back from bits 6:0, and its upper bits read 0.
- R9: The interrupt output is high exactly when at least one flag is set whose mask bit is also set.
- R10: Status bit 11 follows the receive-shift-full input and bit 12 follows the bus-busy input. Both are read-only, cannot be masked, and never produce a vector or an interrupt.
- R11: Register addresses are 0 status, 1 mask, 2 vector; address 3 reads 0. Read data appears one cycle after the read strobe and holds while no read occurs. Writes to the vector register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| evt_pulse | input | 7 | One-cycle event pulses from the bus engine |
| bus_busy | input | 1 | Bus-busy level |
| rx_shift_full | input | 1 | Receive-shift-full level |
| irq | output | 1 | Interrupt request |

## Verification
The bench first raises all seven events together with everything masked. This separates flag capture from vector and interrupt generation. It then enables all events and drains them one by one, which shows the full code order and the clear-on-read behaviour. Partial masks with a lower-priority masked flag pending show that masked flags are skipped without being lost. Mixed writes, the same-cycle read and re-raise case, and long random traffic with the level inputs toggling are compared every clock against a behavioural model. Together these distinguish set-versus-clear precedence, write-one-to-clear limits and the read-only bits.

// File: rtl/ivs_pkg.sv
`timescale 1ns/1ps
package ivs_pkg;
  localparam int NEV     = 7;
  localparam int DW      = 16;
  localparam int AW      = 2;
  localparam int VW      = $clog2(NEV + 1);
  localparam int RSF_BIT = 11;
  localparam int BB_BIT  = 12;

  typedef enum logic [AW-1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_VEC  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // only access-ready (2) and stop-detected (5) may be cleared by writing 1
  localparam logic [NEV-1:0] W1C_BITS = 7'b010_0100;
endpackage

// File: rtl/ivs_flag_bank.sv
`timescale 1ns/1ps
module ivs_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end

    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ivs_mask_reg.sv
`timescale 1ns/1ps
module ivs_mask_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/ivs_prio_enc.sv
`timescale 1ns/1ps
module ivs_prio_enc #(
  parameter int N  = 7,
  parameter int VW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [VW-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = VW'(i + 1);
    end
  end
endmodule

// File: rtl/i2c_irq_vector_unit.sv
`timescale 1ns/1ps
module i2c_irq_vector_unit
  import ivs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_rd,
  output logic [DW-1:0] reg_rdata,
  input  logic [NEV-1:0] evt_pulse,
  input  logic          bus_busy,
  input  logic          rx_shift_full,
  output logic          irq
);
  logic [NEV-1:0] flags;
  logic [NEV-1:0] mask;
  logic [NEV-1:0] pend;
  logic [NEV-1:0] vec_clr;
  logic [NEV-1:0] w1c_clr;
  logic [NEV-1:0] below;
  logic [VW-1:0]  vec;
  logic [DW-1:0]  stat_word;
  logic [DW-1:0]  mask_word;
  logic           rd_vec;
  logic           unused_wdata;

  assign unused_wdata = ^reg_wdata[DW-1:NEV];

  ivs_flag_bank #(.N(NEV)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_i(evt_pulse), .clr_i(vec_clr | w1c_clr), .flag_o(flags)
  );

  ivs_mask_reg #(.N(NEV)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_wr && (reg_addr == A_MASK)),
    .wdata_i(reg_wdata[NEV-1:0]), .mask_o(mask)
  );

  assign pend = flags & mask;

  ivs_prio_enc #(.N(NEV), .VW(VW)) u_enc (.req_i(pend), .vec_o(vec));

  assign irq    = |pend;
  assign rd_vec = reg_rd && (reg_addr == A_VEC);

  always_comb begin
    for (int i = 0; i < NEV; i++) begin
      vec_clr[i] = rd_vec && (vec == VW'(i + 1));
      below[i]   = (VW'(i + 1) < vec);
    end
  end

  assign w1c_clr = (reg_wr && (reg_addr == A_STAT)) ? (reg_wdata[NEV-1:0] & W1C_BITS) : '0;

  always_comb begin
    stat_word          = '0;
    stat_word[NEV-1:0] = flags;
    stat_word[RSF_BIT] = rx_shift_full;
    stat_word[BB_BIT]  = bus_busy;
    mask_word          = '0;
    mask_word[NEV-1:0] = mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STAT:  reg_rdata <= stat_word;
        A_MASK:  reg_rdata <= mask_word;
        A_VEC:   reg_rdata <= DW'(vec);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '0) |-> ((pend & below) == '0));

  // R5
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == '0) == (pend == '0));

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec != '0));

  // R6
  one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_clr));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_i2c_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_i2c_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        bus_busy = 1'b0;
  logic        rx_shift_full = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  i2c_irq_vector_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .bus_busy(bus_busy), .rx_shift_full(rx_shift_full),
    .irq(irq)
  );

  // behavioural reference model
  bit [6:0]  m_flag;
  bit [6:0]  m_mask;
  bit [15:0] m_rdata;
  string     m_tag = "R1";

  function automatic int lowest_code(bit [6:0] p);
    for (int i = 0; i < 7; i++) if (p[i]) return i + 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = '0; m_mask = '0; m_rdata = '0; m_tag = "R1";
    end else begin
      int v;
      bit [6:0] clr;
      v   = lowest_code(m_flag & m_mask);
      clr = '0;
      if (reg_rd) begin
        case (reg_addr)
          2'd0: begin
            m_rdata = {3'b0, bus_busy, rx_shift_full, 4'b0, m_flag};
            m_tag = "R2";
          end
          2'd1: begin m_rdata = {9'b0, m_mask}; m_tag = "R8"; end
          2'd2: begin
            m_rdata = 16'(v); m_tag = "R4";
            if (v != 0) clr[v-1] = 1'b1;
          end
          default: begin m_rdata = '0; m_tag = "R11"; end
        endcase
      end
      if (reg_wr && reg_addr == 2'd0) begin
        clr[2] = clr[2] | reg_wdata[2];
        clr[5] = clr[5] | reg_wdata[5];
      end
      if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata[6:0];
      m_flag = (m_flag & ~clr) | evt_pulse;
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (irq !== ((m_flag & m_mask) != 0)) begin
        fails++;
        $display("FAIL R9 irq actual=%0b expected=%0b at %0t", irq, ((m_flag & m_mask) != 0), $time);
      end
      checks++;
      if (reg_rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h at %0t", m_tag, reg_rdata, m_rdata, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at posedge+2; drives one cycle, returns at next posedge+2
  task automatic step(input logic [1:0] a, input logic rd, input logic wr,
                      input logic [15:0] wd, input logic [6:0] ev);
    reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd; evt_pulse = ev;
    @(posedge clk); #2;
    reg_rd = 1'b0; reg_wr = 1'b0; evt_pulse = '0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    step(a, 1'b1, 1'b0, 16'h0, 7'h0);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: reset state
    chk("R1", {15'b0, irq}, 16'h0);
    chk("R1", reg_rdata, 16'h0);
    rd_chk(2'd0, 16'h0000, "R1");
    rd_chk(2'd1, 16'h0000, "R1");
    rd_chk(2'd2, 16'h0000, "R1");

    // R2/R5: all events while fully masked
    step(2'd0, 0, 0, 16'h0, 7'h7F);
    chk("R5", {15'b0, irq}, 16'h0);
    rd_chk(2'd0, 16'h007F, "R2");
    rd_chk(2'd2, 16'h0000, "R5");

    // R3/R4/R6: enable all, drain in code order
    step(2'd1, 0, 1, 16'h007F, 7'h0);
    chk("R9", {15'b0, irq}, 16'h1);
    for (int k = 1; k <= 7; k++) rd_chk(2'd2, 16'(k), "R3");
    rd_chk(2'd2, 16'h0000, "R6");
    chk("R9", {15'b0, irq}, 16'h0);
    rd_chk(2'd0, 16'h0000, "R6");

    // R7: write-one-to-clear only on bits 2 and 5
    step(2'd0, 0, 0, 16'h0, 7'h25);
    step(2'd0, 0, 1, 16'hFFFF, 7'h0);
    rd_chk(2'd0, 16'h0001, "R7");
    rd_chk(2'd2, 16'h0001, "R7");

    // R8/R4/R5: partial mask, lower-priority flag masked
    step(2'd1, 0, 1, 16'hFFA0, 7'h0);
    rd_chk(2'd1, 16'h0020, "R8");
    step(2'd0, 0, 0, 16'h0, 7'h21);
    rd_chk(2'd2, 16'h0006, "R4");
    rd_chk(2'd2, 16'h0000, "R5");
    rd_chk(2'd0, 16'h0001, "R5");
    chk("R9", {15'b0, irq}, 16'h0);
    step(2'd1, 0, 1, 16'hFFFF, 7'h0);
    rd_chk(2'd1, 16'h007F, "R8");

    // R6: vector read coinciding with a new pulse of the same event
    step(2'd2, 1, 0, 16'h0, 7'h01);
    chk("R6", reg_rdata, 16'h0001);
    rd_chk(2'd0, 16'h0001, "R6");
    rd_chk(2'd2, 16'h0001, "R3");

    // R10: level bits are read-only, unmaskable, no vector
    bus_busy = 1'b1; rx_shift_full = 1'b1;
    rd_chk(2'd0, 16'h1800, "R10");
    rd_chk(2'd2, 16'h0000, "R10");
    chk("R10", {15'b0, irq}, 16'h0);
    step(2'd0, 0, 1, 16'hFFFF, 7'h0);
    rd_chk(2'd0, 16'h1800, "R10");
    bus_busy = 1'b0; rx_shift_full = 1'b0;

    // R11: unused address, ignored vector write, read data hold
    rd_chk(2'd3, 16'h0000, "R11");
    step(2'd0, 0, 0, 16'h0, 7'h08);
    step(2'd2, 0, 1, 16'h0003, 7'h0);
    rd_chk(2'd2, 16'h0004, "R11");
    rd_chk(2'd1, 16'h007F, "R11");
    step(2'd0, 0, 0, 16'h0, 7'h40);
    chk("R11", reg_rdata, 16'h007F);
    rd_chk(2'd2, 16'h0007, "R3");

    // random traffic, model-compared each clock
    for (int n = 0; n < 3000; n++) begin
      bus_busy      = ($urandom_range(0, 3) == 0);
      rx_shift_full = ($urandom_range(0, 3) == 0);
      step(2'($urandom_range(0, 3)), ($urandom_range(0, 1) == 1),
           ($urandom_range(0, 5) == 0), 16'($urandom),
           7'($urandom) & 7'($urandom) & 7'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule